// File: doc/BRIEF.md
# Synchronous Half-Duplex Frame Transceiver

This block is the programmer-side physical layer of a two-wire programming link. It makes the link clock by dividing the system clock. It moves bytes over a single shared, bidirectional data pin, using UART-style frames timed by that clock. An upper layer hands it bytes to send through a valid/ready pair. Received bytes come back as a one-cycle pulse, together with parity and framing error flags. The block can also send a break frame, and it reports a received break separately from ordinary data.

Each frame has 12 bit periods, in this order:

| Period | Content |
|---|---|
| 0 | Start bit, low |
| 1 to 8 | Eight data bits, least significant first |
| 9 | Even parity bit |
| 10 and 11 | Two stop bits, high |

Both sides change data on the falling edge of the link clock and sample it on the rising edge. The link is half-duplex:

- By default the pad is released and the receiver waits for a start bit.
- The block takes the pad for one frame at a time.
- After the frame it releases the pad and waits one full link clock cycle of guard before it listens again.
- While it drives, it compares what it reads back on every rising edge. Any mismatch is reported as a collision.

Top module: `sync_frame_xcvr`

## Requirements
- R1: Out of reset the pad is released (`dat_oe`=0), `dat_o` is 1, the link clock is high, no receive pulse is raised, and `tx_ready` stays 0 while `link_en` is 0.
- R2: While `link_en` is 1, the link clock toggles every `DIV_HALF` system cycles, so its period is 2*`DIV_HALF` cycles. While `link_en` is 0, the link clock is held high.
- R3: A transmitted frame is 12 bit periods, in order: period 0 is a 0 start bit, periods 1 to 8 are data bits 0 to 7, period 9 is the XOR of the eight data bits, and periods 10 and 11 are stop bits of 1.
- R4: `dat_o` changes only in the cycle where the link clock has just fallen. `dat_oe` rises on the falling edge that puts out the start bit and stays high through the last stop bit.
- R5: `dat_oe` drops on the falling edge after the last stop bit. `tx_ready` returns only on the falling edge after that, one full link clock cycle later.
- R6: While listening, a rising-edge sample of 0 marks a start bit. The next eleven rising-edge samples are collected. Unless R9 applies, `rx_valid` then pulses for one cycle, with `rx_data` taken least significant bit first.
- R7: `rx_parity_err` is set with `rx_valid` when the received parity bit differs from the XOR of the received data bits.
- R8: `rx_frame_err` is set with `rx_valid` when either received stop bit is 0.
- R9: A received frame whose eleven bits after the start bit are all 0 pulses `rx_break` instead of `rx_valid`.
- R10: A transmit accepted with `tx_break`=1 sends 12 periods of 0, whatever `tx_data` is.
- R11: During a transmit, every rising edge at which `dat_i` differs from the driven bit gives a one-cycle `tx_collision` pulse.
- R12: `tx_ready` is 0 while a frame is being received, transmitted or guarded. A frame the block transmits itself never produces `rx_valid` or `rx_break`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| link_en | input | 1 | Runs the link clock; when 0, the clock idles high and the link returns to listening |
| tx_valid | input | 1 | Upper layer offers a frame to send |
| tx_break | input | 1 | The offered frame is a break frame |
| tx_data | input | 8 | Byte to send |
| tx_ready | output | 1 | The block will accept an offered frame this cycle |
| rx_valid | output | 1 | One-cycle pulse: a received byte is ready |
| rx_data | output | 8 | Last received byte |
| rx_parity_err | output | 1 | Parity flag of the last received byte |
| rx_frame_err | output | 1 | Stop-bit flag of the last received byte |
| rx_break | output | 1 | One-cycle pulse: a break frame was received |
| tx_collision | output | 1 | One-cycle pulse: the read-back differed from the driven bit |
| link_clk_o | output | 1 | Generated link clock |
| dat_o | output | 1 | Data pad output value |
| dat_oe | output | 1 | Data pad output enable |
| dat_i | input | 1 | Data pad input value |

## Verification
The bench goes after the four bits a frame can get wrong:

- **Start, parity and stop positions.** It uses all-zero and all-one bytes, where a swapped bit order or an odd-parity slip changes the whole frame vector.
- **Pad release and guard timing.** A design that dropped the guard cycle would raise `tx_ready` on the rising edge right after release. One that held the pad would still show `dat_oe` high there.
- **Receive error and break decoding.** Frames with a flipped parity bit, a low first stop and a low second stop must each raise only their own flag. An all-zero frame must raise a break and not a byte.
- **Collisions and self-reception.** With the line pulled low during a transmit, the number of collision pulses must equal the number of 1 bits in the frame. A design that listened to its own transmit would show extra receive pulses.

// File: rtl/sfx_pkg.sv
// Shared definitions for the synchronous half-duplex frame transceiver.
// Assumes: fixed frame of one start, eight data, even parity, two stop bits.
package sfx_pkg;
    localparam int DATA_BITS  = 8;
    localparam int FRAME_BITS = DATA_BITS + 4;

    typedef enum logic [1:0] {
        DIR_LISTEN = 2'd0,
        DIR_TALK   = 2'd1,
        DIR_GUARD  = 2'd2
    } dir_t;

    // Build the bit sequence of one frame, period 0 in bit 0.
    function automatic logic [FRAME_BITS-1:0] build_frame(
        input logic [DATA_BITS-1:0] data,
        input logic                 brk
    );
        if (brk) return '0;
        return {2'b11, ^data, data, 1'b0};
    endfunction
endpackage

// File: rtl/sfx_clk_gen.sv
// Link clock generator: divides the system clock by 2*DIV_HALF.
// Gives one-cycle strobes in the system cycle whose closing edge makes the
// link clock rise or fall. Assumes DIV_HALF >= 1. Held high when en is 0.
module sfx_clk_gen #(
    parameter int DIV_HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic link_clk,
    output logic rise_stb,
    output logic fall_stb
);
    localparam int CW = $clog2(DIV_HALF + 1);

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap     = en && (cnt == CW'(DIV_HALF - 1));
    assign rise_stb = wrap && !link_clk;
    assign fall_stb = wrap &&  link_clk;

    // Half-period counter and clock toggle; idle high while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt      <= '0;
            link_clk <= 1'b1;
        end else if (wrap) begin
            cnt      <= '0;
            link_clk <= ~link_clk;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R2
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> link_clk);

    // R2
    rise_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |=> $rose(link_clk));
endmodule

// File: rtl/sfx_tx_frame.sv
// Transmit shifter: loads one frame and puts out one bit per step.
// Assumes step is only given at falling link-clock edges of a transmit.
// done is high once all frame bits have been put out.
module sfx_tx_frame
    import sfx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 brk,
    input  logic [DATA_BITS-1:0] data,
    input  logic                 step,
    output logic                 bit_o,
    output logic                 done
);
    localparam int NW = $clog2(FRAME_BITS + 1);

    logic [FRAME_BITS-1:0] shreg;
    logic [NW-1:0]         sent;

    assign done = (sent == NW'(FRAME_BITS));

    // Frame load and per-step shift of the outgoing bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            sent  <= NW'(FRAME_BITS);
            bit_o <= 1'b1;
        end else if (load) begin
            shreg <= build_frame(data, brk);
            sent  <= '0;
        end else if (step && !done) begin
            bit_o <= shreg[0];
            shreg <= shreg >> 1;
            sent  <= sent + 1'b1;
        end
    end

    // R3
    no_step_past_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && done) |=> $stable(bit_o));
endmodule

// File: rtl/sfx_rx_frame.sv
// Receive collector: finds a start bit, gathers the next eleven samples and
// decodes data, parity, stop bits and break. Samples only on rising strobes.
// Assumes listen is low whenever the pad is being driven by this side.
module sfx_rx_frame
    import sfx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 listen,
    input  logic                 rise_stb,
    input  logic                 bit_i,
    output logic                 busy,
    output logic                 valid,
    output logic                 brk,
    output logic [DATA_BITS-1:0] data,
    output logic                 perr,
    output logic                 ferr
);
    localparam int BODY = FRAME_BITS - 1;
    localparam int CW   = $clog2(BODY + 1);

    logic [BODY-1:0] body;
    logic [BODY-1:0] nxt;
    logic [CW-1:0]   got;

    assign nxt = {bit_i, body[BODY-1:1]};

    // Start detection, sample collection and frame decode.
    always_ff @(posedge clk) begin
        valid <= 1'b0;
        brk   <= 1'b0;
        if (!rst_n || clr) begin
            busy <= 1'b0;
            got  <= '0;
            body <= '0;
            if (!rst_n) begin
                data <= '0;
                perr <= 1'b0;
                ferr <= 1'b0;
            end
        end else if (rise_stb) begin
            if (!busy) begin
                if (listen && !bit_i) begin
                    busy <= 1'b1;
                    got  <= '0;
                end
            end else begin
                body <= nxt;
                got  <= got + 1'b1;
                if (got == CW'(BODY - 1)) begin
                    busy <= 1'b0;
                    if (nxt == '0) begin
                        brk <= 1'b1;
                    end else begin
                        valid <= 1'b1;
                        data  <= nxt[DATA_BITS-1:0];
                        perr  <= nxt[DATA_BITS] ^ (^nxt[DATA_BITS-1:0]);
                        ferr  <= ~&nxt[BODY-1:DATA_BITS+1];
                    end
                end
            end
        end
    end

    // R9
    break_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid && brk));

    // R6
    pulse_after_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid || brk) |-> $past(rise_stb));
endmodule

// File: rtl/sync_frame_xcvr.sv
// Synchronous half-duplex frame transceiver, programmer side.
// Generates the link clock, owns the pad direction and joins the
// transmit shifter and receive collector. Listens by default; one frame is
// transmitted per accepted request, followed by a one-link-cycle guard.
module sync_frame_xcvr
    import sfx_pkg::*;
#(
    parameter int DIV_HALF = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 link_en,
    input  logic                 tx_valid,
    input  logic                 tx_break,
    input  logic [DATA_BITS-1:0] tx_data,
    output logic                 tx_ready,
    output logic                 rx_valid,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_parity_err,
    output logic                 rx_frame_err,
    output logic                 rx_break,
    output logic                 tx_collision,
    output logic                 link_clk_o,
    output logic                 dat_o,
    output logic                 dat_oe,
    input  logic                 dat_i
);
    dir_t dir;
    logic rise_stb, fall_stb;
    logic accept, tx_step, tx_done, rx_busy;

    sfx_clk_gen #(.DIV_HALF(DIV_HALF)) u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (link_en),
        .link_clk (link_clk_o),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    assign tx_ready = link_en && (dir == DIR_LISTEN) && !rx_busy;
    assign accept   = tx_valid && tx_ready;
    assign tx_step  = (dir == DIR_TALK) && fall_stb && !tx_done;

    sfx_tx_frame u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .brk   (tx_break),
        .data  (tx_data),
        .step  (tx_step),
        .bit_o (dat_o),
        .done  (tx_done)
    );

    sfx_rx_frame u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (!link_en),
        .listen   ((dir == DIR_LISTEN) && !accept),
        .rise_stb (rise_stb),
        .bit_i    (dat_i),
        .busy     (rx_busy),
        .valid    (rx_valid),
        .brk      (rx_break),
        .data     (rx_data),
        .perr     (rx_parity_err),
        .ferr     (rx_frame_err)
    );

    // Pad direction sequencing: listen, talk one frame, guard one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || !link_en) begin
            dir    <= DIR_LISTEN;
            dat_oe <= 1'b0;
        end else begin
            unique case (dir)
                DIR_LISTEN: if (accept) dir <= DIR_TALK;
                DIR_TALK: if (fall_stb) begin
                    if (tx_done) begin
                        dat_oe <= 1'b0;
                        dir    <= DIR_GUARD;
                    end else begin
                        dat_oe <= 1'b1;
                    end
                end
                DIR_GUARD: if (fall_stb) dir <= DIR_LISTEN;
                default: dir <= DIR_LISTEN;
            endcase
        end
    end

    // Read-back compare on each rising edge while driving.
    always_ff @(posedge clk) begin
        if (!rst_n) tx_collision <= 1'b0;
        else        tx_collision <= (dir == DIR_TALK) && dat_oe && rise_stb && (dat_i != dat_o);
    end

    // R4
    dat_change_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dat_o) |-> $fell(link_clk_o));

    // R4
    oe_rise_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dat_oe) |-> $fell(link_clk_o));

    // R5
    oe_drop_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dat_oe) && $past(link_en)) |-> $fell(link_clk_o));

    // R12
    no_rx_while_driving_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dat_oe |-> !rx_busy);

    // R11
    collision_only_driving_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_collision |-> dat_oe);
endmodule

// File: tb/test_sync_frame_xcvr.sv
// Bench for sync_frame_xcvr: seeded random bytes plus directed corner frames.
module test_sync_frame_xcvr;
    localparam int DH = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       link_en = 1'b0;
    logic       tx_valid = 1'b0;
    logic       tx_break = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_ready, rx_valid, rx_parity_err, rx_frame_err, rx_break;
    logic       tx_collision, link_clk_o, dat_o, dat_oe;
    logic [7:0] rx_data;
    logic       bench_drv = 1'b1;
    logic       bench_col = 1'b0;
    wire        line = dat_oe ? (dat_o & ~bench_col) : bench_drv;

    int checks = 0, fails = 0, cyc = 0;
    int v_cnt = 0, b_cnt = 0, col_cnt = 0;
    logic [7:0] got_data;
    logic       got_pe, got_fe;

    always #5 clk = ~clk;

    sync_frame_xcvr #(.DIV_HALF(DH)) i_sync_frame_xcvr (
        .clk(clk), .rst_n(rst_n), .link_en(link_en),
        .tx_valid(tx_valid), .tx_break(tx_break), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_parity_err(rx_parity_err),
        .rx_frame_err(rx_frame_err), .rx_break(rx_break), .tx_collision(tx_collision),
        .link_clk_o(link_clk_o), .dat_o(dat_o), .dat_oe(dat_oe), .dat_i(line)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Capture receive and collision pulses away from the active edge.
    always @(negedge clk) begin
        if (rx_valid) begin
            v_cnt++;
            got_data = rx_data;
            got_pe   = rx_parity_err;
            got_fe   = rx_frame_err;
        end
        if (rx_break) b_cnt++;
        if (tx_collision) col_cnt++;
    end

    function automatic logic [11:0] exp_frame(input logic [7:0] d, input logic brk);
        return brk ? 12'h000 : {2'b11, ^d, d, 1'b0};
    endfunction

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Send one frame from the block and check its bits, release and guard.
    task automatic do_tx(input logic [7:0] d, input logic brk, input logic col);
        logic [11:0] bits;
        int v0, b0;
        v0 = v_cnt; b0 = b_cnt; col_cnt = 0;
        bench_col = col;
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        tx_valid = 1'b1; tx_data = d; tx_break = brk;
        @(negedge clk);
        tx_valid = 1'b0; tx_break = 1'b0;
        while (!dat_oe) @(negedge clk);
        for (int i = 0; i < 12; i++) begin
            @(posedge link_clk_o);
            @(negedge clk);
            bits[i] = dat_o;
            if (i == 5) check(tx_ready == 1'b0, "R12 ready low in tx", int'(tx_ready), 0);
        end
        if (brk) check(bits == 12'h000, "R10 break frame", int'(bits), 0);
        else     check(bits == exp_frame(d, 1'b0), "R3 tx frame", int'(bits), int'(exp_frame(d, 1'b0)));
        @(posedge link_clk_o);
        @(negedge clk);
        check(dat_oe == 1'b0 && tx_ready == 1'b0, "R5 released, guard",
              int'({dat_oe, tx_ready}), 0);
        @(negedge link_clk_o);
        @(negedge clk);
        check(tx_ready == 1'b1, "R5 ready after guard", int'(tx_ready), 1);
        check(v_cnt == v0 && b_cnt == b0, "R12 no self receive", v_cnt - v0 + b_cnt - b0, 0);
        if (col) check(col_cnt == $countones(exp_frame(d, brk)), "R11 collisions",
                       col_cnt, $countones(exp_frame(d, brk)));
        else     check(col_cnt == 0, "R11 no collision", col_cnt, 0);
        bench_col = 1'b0;
    endtask

    // Drive one frame into the block as the far side would.
    task automatic do_rx(input logic [11:0] f);
        int v0, b0;
        logic [7:0] d;
        logic pe, fe;
        v0 = v_cnt; b0 = b_cnt;
        @(negedge link_clk_o);
        for (int i = 0; i < 12; i++) begin
            bench_drv = f[i];
            if (i == 4) begin
                @(negedge clk);
                check(tx_ready == 1'b0, "R12 ready low in rx", int'(tx_ready), 0);
            end
            @(negedge link_clk_o);
        end
        bench_drv = 1'b1;
        @(negedge clk);
        d  = f[8:1];
        pe = f[9] ^ (^d);
        fe = ~(f[10] & f[11]);
        if (f[11:1] == 11'h0) begin
            check(b_cnt == b0 + 1 && v_cnt == v0, "R9 break rx", b_cnt - b0, 1);
        end else begin
            check(v_cnt == v0 + 1 && b_cnt == b0, "R6 one rx pulse", v_cnt - v0, 1);
            check(got_data == d, "R6 rx data", int'(got_data), int'(d));
            check(got_pe == pe, "R7 parity flag", int'(got_pe), int'(pe));
            check(got_fe == fe, "R8 frame flag", int'(got_fe), int'(fe));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int t0, t1, toggles;
        logic [7:0] r;
        void'($urandom(32'h5EED));
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(link_clk_o && !dat_oe && dat_o && !tx_ready && !rx_valid && !rx_break,
              "R1 reset state", int'({link_clk_o, dat_oe, dat_o, tx_ready}), 4'b1010);
        toggles = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (!link_clk_o) toggles++;
        end
        check(toggles == 0, "R2 idle high", toggles, 0);
        link_en = 1'b1;
        @(posedge link_clk_o); t0 = cyc;
        @(posedge link_clk_o); t1 = cyc;
        check(t1 - t0 == 2 * DH, "R2 link period", t1 - t0, 2 * DH);

        // Directed transmit corners.
        do_tx(8'h00, 1'b0, 1'b0);
        do_tx(8'hFF, 1'b0, 1'b0);
        do_tx(8'hA5, 1'b1, 1'b0);
        do_tx(8'h3C, 1'b0, 1'b1);
        do_tx(8'h5A, 1'b1, 1'b1);
        for (int i = 0; i < 10; i++) begin
            r = 8'($urandom);
            do_tx(r, 1'b0, 1'($urandom % 4 == 0));
        end

        // Directed receive corners: parity, each stop bit, break.
        do_rx(exp_frame(8'h00, 1'b0));
        do_rx(exp_frame(8'hFF, 1'b0));
        do_rx(exp_frame(8'h81, 1'b0) ^ 12'h200);
        do_rx(exp_frame(8'h42, 1'b0) & ~12'h400);
        do_rx(exp_frame(8'h42, 1'b0) & ~12'h800);
        do_rx(12'h000);
        for (int i = 0; i < 10; i++) begin
            r = 8'($urandom);
            do_rx(exp_frame(r, 1'b0) ^ ((($urandom % 3) == 0) ? 12'h200 : 12'h000));
        end

        // Transmit after receive still clean.
        do_tx(8'hC3, 1'b0, 1'b0);

        // R2 disabling holds the clock high again.
        link_en = 1'b0;
        repeat (2) @(negedge clk);
        toggles = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (!link_clk_o) toggles++;
        end
        check(toggles == 0 && !tx_ready, "R2 disabled high", toggles, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule